// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block sits between a clocked host and a 32K x 8 asynchronous static RAM. The host raises a request with a write flag, a 15-bit word address and, for writes, one data byte. The controller then runs the active-low chip-select, write-strobe and output-enable sequence that the memory needs. It returns the read byte together with a one-cycle completion pulse. Only one access is in flight at a time. A new request is taken only while the controller is idle.

Every phase length comes from a minimum time in nanoseconds and a clock-period parameter. Each length is the ceiling of time over period, and never less than one cycle. A read keeps select and output-enable low for the longer of the read-cycle, address-access and enable-access times. It captures the memory byte on the last cycle of that phase. It then waits out the output-float time with all strobes high. A write keeps output-enable high throughout and holds the write strobe low long enough to cover the pulse width, data setup and select/address setup. It then holds address and data for at least one further cycle after the strobe rises, and longer if the write-cycle minimum requires it. Because of the turnaround wait, the data drivers never switch on while the memory outputs may still be active.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, and `mem_drv` and `host_done` are 0. Asserting reset in the middle of an access returns all strobes to 1 and `mem_drv` to 0 at once.
- R2: A read keeps `mem_ce_n` and `mem_oe_n` at 0 and `mem_we_n` at 1 for exactly RD_CYC consecutive cycles. RD_CYC is 4 at the default parameters (20 ns clock, 70 ns cycle and access). `mem_addr` equals the requested address throughout that phase.
- R3: `host_rdata` presents the byte on `mem_din` in the last cycle of the read phase, and it is valid while `host_done` is high.
- R4: A write keeps `mem_ce_n` and `mem_we_n` at 0 for exactly WP_CYC consecutive cycles (3 at defaults). `mem_oe_n` stays 1 and `mem_drv` stays 1 with `mem_dout` equal to the write byte.
- R5: After `mem_we_n` rises, `mem_drv`, `mem_addr` and `mem_dout` are held for WH_CYC more cycles (1 at defaults) with `mem_ce_n` at 1. The write therefore spans at least the write-cycle minimum.
- R6: `mem_drv` is never 1 while `mem_oe_n` is 0. After a read, `mem_drv` stays 0 for at least TA_CYC cycles (2 at defaults) after `mem_oe_n` rises, and is 0 throughout the read.
- R7: `host_done` is a single-cycle pulse. It rises RD_CYC+TA_CYC+1 cycles after the accepting edge for a read (7 at defaults) and WP_CYC+WH_CYC+1 cycles after it for a write (5 at defaults).
- R8: A request held or raised while an access is in progress is ignored. It causes no extra strobe cycle, no memory write and no extra completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, sampled while idle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write byte |
| host_rdata | output | DATA_W | Read byte, valid with host_done |
| host_done | output | 1 | One-cycle completion pulse |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Data driven toward the memory |
| mem_drv | output | 1 | Enable for the data drivers |
| mem_din | input | DATA_W | Data returned by the memory |

## Verification
The bound checker watches these properties on every cycle:
- the drivers and output-enable never overlap;
- the write strobe only goes low under select, with output-enable high;
- the strobe low-width and the read-phase length reach their minimum counts;
- address and data are still held at the cycle the write strobe rises;
- the turnaround gap precedes every driver enable;
- the completion pulse lasts one cycle.

Only the bench's scenarios can show the rest. A memory model in the bench returns valid data only from the fourth read cycle on, which exposes the capture point. The bench also checks the exact latencies, that written bytes reach the right locations and read back, and that requests arriving mid-access are dropped.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_READ  = 3'd1,
      PH_TURN  = 3'd2,
      PH_WRITE = 3'd3,
      PH_WHOLD = 3'd4
   } phase_e;

   // Whole clock cycles covering a minimum time, never below one.
   function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
      int c;
      c = (t_ns + clk_ns - 1) / clk_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_strobe_fsm.sv
module sram_strobe_fsm
   import sram_strobe_pkg::*;
#(
   parameter int CNT_W  = 3,
   parameter int RD_CYC = 4,
   parameter int WP_CYC = 3,
   parameter int WH_CYC = 1,
   parameter int TA_CYC = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   req,
   input  logic   wr,
   output phase_e phase_q,
   output phase_e phase_nxt,
   output logic   accept,
   output logic   capture,
   output logic   finish
);

   localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
   localparam logic [CNT_W-1:0] WH_LD = CNT_W'(WH_CYC - 1);
   localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TA_CYC - 1);

   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_done;

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   always_comb begin
      phase_nxt = phase_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      accept    = 1'b0;
      capture   = 1'b0;
      finish    = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (req) begin
               accept    = 1'b1;
               tmr_load  = 1'b1;
               phase_nxt = wr ? PH_WRITE : PH_READ;
               tmr_val   = wr ? WP_LD : RD_LD;
            end
         end
         PH_READ: begin
            if (tmr_done) begin
               capture   = 1'b1;
               tmr_load  = 1'b1;
               tmr_val   = TA_LD;
               phase_nxt = PH_TURN;
            end
         end
         PH_TURN: begin
            if (tmr_done) begin
               finish    = 1'b1;
               phase_nxt = PH_IDLE;
            end
         end
         PH_WRITE: begin
            if (tmr_done) begin
               tmr_load  = 1'b1;
               tmr_val   = WH_LD;
               phase_nxt = PH_WHOLD;
            end
         end
         PH_WHOLD: begin
            if (tmr_done) begin
               finish    = 1'b1;
               phase_nxt = PH_IDLE;
            end
         end
         default: phase_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_nxt;
   end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
   import sram_strobe_pkg::*;
#(
   parameter int ADDR_W    = 15,
   parameter int DATA_W    = 8,
   parameter int CLK_NS    = 20,
   parameter int T_RC_NS   = 70,
   parameter int T_AA_NS   = 70,
   parameter int T_DOE_NS  = 35,
   parameter int T_HZOE_NS = 25,
   parameter int T_WC_NS   = 70,
   parameter int T_PWE_NS  = 50,
   parameter int T_SD_NS   = 30,
   parameter int T_AW_NS   = 60,
   parameter int T_SCE_NS  = 60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_done,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_drv,
   input  logic [DATA_W-1:0] mem_din
);

   // Phase lengths in clock cycles.
   localparam int RD_CYC = imax(imax(ns_to_cycles(T_AA_NS, CLK_NS),
                                     ns_to_cycles(T_DOE_NS, CLK_NS)),
                                ns_to_cycles(T_RC_NS, CLK_NS));
   localparam int WP_CYC = imax(imax(ns_to_cycles(T_PWE_NS, CLK_NS),
                                     ns_to_cycles(T_SD_NS, CLK_NS)),
                                imax(ns_to_cycles(T_AW_NS, CLK_NS),
                                     ns_to_cycles(T_SCE_NS, CLK_NS)));
   localparam int WC_CYC = ns_to_cycles(T_WC_NS, CLK_NS);
   localparam int WH_CYC = imax(WC_CYC - WP_CYC, 1);
   localparam int TA_CYC = ns_to_cycles(T_HZOE_NS, CLK_NS);
   localparam int CNT_MAX = imax(imax(RD_CYC, WP_CYC), imax(WH_CYC, TA_CYC));
   localparam int CNT_W  = imax($clog2(CNT_MAX + 1), 1);

   // Elaboration-time parameter checks.
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
      $error("sram_strobe_ctrl: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("sram_strobe_ctrl: DATA_W must be positive");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("sram_strobe_ctrl: CLK_NS must be positive");
   end

   phase_e phase_q, phase_nxt;
   logic   accept, capture, finish;

   sram_strobe_fsm #(
      .CNT_W  (CNT_W),
      .RD_CYC (RD_CYC),
      .WP_CYC (WP_CYC),
      .WH_CYC (WH_CYC),
      .TA_CYC (TA_CYC)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (host_req),
      .wr        (host_wr),
      .phase_q   (phase_q),
      .phase_nxt (phase_nxt),
      .accept    (accept),
      .capture   (capture),
      .finish    (finish)
   );

   // Strobes are registered from the next phase so they leave flops cleanly.
   logic nxt_sel, nxt_rd, nxt_wr, nxt_drv;
   assign nxt_sel = (phase_nxt == PH_READ) || (phase_nxt == PH_WRITE);
   assign nxt_rd  = (phase_nxt == PH_READ);
   assign nxt_wr  = (phase_nxt == PH_WRITE);
   assign nxt_drv = (phase_nxt == PH_WRITE) || (phase_nxt == PH_WHOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_ce_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_drv   <= 1'b0;
         host_done <= 1'b0;
      end else begin
         mem_ce_n  <= !nxt_sel;
         mem_oe_n  <= !nxt_rd;
         mem_we_n  <= !nxt_wr;
         mem_drv   <= nxt_drv;
         host_done <= finish;
      end
   end

   // Address and write data are loaded only at acceptance, so they stay
   // put through the hold phase.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         mem_dout <= '0;
      end else if (accept) begin
         mem_addr <= host_addr;
         mem_dout <= host_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       host_rdata <= '0;
      else if (capture) host_rdata <= mem_din;
   end

   logic unused_phase;
   assign unused_phase = ^phase_q;

endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk #(
   parameter int ADDR_W = 15,
   parameter int RD_CYC = 4,
   parameter int WP_CYC = 3,
   parameter int TA_CYC = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_done,
   input logic              mem_ce_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic              mem_drv,
   input logic [ADDR_W-1:0] mem_addr
);

   localparam logic [15:0] SAT = 16'hFFFF;

   logic [15:0] we_lo_cnt, oe_lo_cnt, oe_hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_lo_cnt <= '0;
         oe_lo_cnt <= '0;
         oe_hi_cnt <= SAT;
      end else begin
         we_lo_cnt <= !mem_we_n ? ((we_lo_cnt == SAT) ? SAT : we_lo_cnt + 1'b1) : '0;
         oe_lo_cnt <= !mem_oe_n ? ((oe_lo_cnt == SAT) ? SAT : oe_lo_cnt + 1'b1) : '0;
         oe_hi_cnt <=  mem_oe_n ? ((oe_hi_cnt == SAT) ? SAT : oe_hi_cnt + 1'b1) : '0;
      end
   end

   AST_RESET_IDLE: assert property (@(posedge clk)
      $rose(rst_n) |-> mem_ce_n && mem_we_n && mem_oe_n && !mem_drv && !host_done); // R1

   AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_ce_n && mem_we_n); // R2

   AST_READ_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> (oe_lo_cnt >= 16'(RD_CYC))); // R2

   AST_WRITE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !mem_ce_n && mem_oe_n && mem_drv); // R4

   AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_lo_cnt >= 16'(WP_CYC))); // R4

   AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> mem_drv && $stable(mem_addr)); // R5

   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      mem_drv |-> mem_oe_n); // R6

   AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_drv) |-> (oe_hi_cnt >= 16'(TA_CYC))); // R6

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      host_done |=> !host_done); // R7

endmodule

bind sram_strobe_ctrl sram_strobe_chk #(
   .ADDR_W (ADDR_W),
   .RD_CYC (RD_CYC),
   .WP_CYC (WP_CYC),
   .TA_CYC (TA_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_done (host_done),
   .mem_ce_n  (mem_ce_n),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .mem_drv   (mem_drv),
   .mem_addr  (mem_addr)
);

// File: tb/sram_strobe_ctrl_bench.sv
module sram_strobe_ctrl_bench;

   // Expected counts at 20 ns clock from the requirements.
   localparam int E_RD  = 4;
   localparam int E_WP  = 3;
   localparam int E_WH  = 1;
   localparam int E_TA  = 2;
   localparam int E_RLAT = E_RD + E_TA + 1;
   localparam int E_WLAT = E_WP + E_WH + 1;

   typedef struct packed {
      logic        wr;
      logic [14:0] a;
      logic [7:0]  d;
      logic [7:0]  x;
   } vec_t;

   // Stimulus with expected read results (x); unwritten bytes hold a[7:0]^8'h5A.
   localparam vec_t VEC [9] = '{
      '{1'b1, 15'h0000, 8'hA5, 8'h00},
      '{1'b1, 15'h7FFF, 8'h3C, 8'h00},
      '{1'b0, 15'h0000, 8'h00, 8'hA5},
      '{1'b0, 15'h7FFF, 8'h00, 8'h3C},
      '{1'b0, 15'h1234, 8'h00, 8'h6E},
      '{1'b1, 15'h1234, 8'hFF, 8'h00},
      '{1'b0, 15'h1234, 8'h00, 8'hFF},
      '{1'b1, 15'h4000, 8'h00, 8'h00},
      '{1'b0, 15'h4000, 8'h00, 8'h00}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0;
   logic        host_wr = 1'b0;
   logic [14:0] host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        host_done;
   logic        mem_ce_n, mem_we_n, mem_oe_n, mem_drv;
   logic [14:0] mem_addr;
   logic [7:0]  mem_dout;
   logic [7:0]  mem_din;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   sram_strobe_ctrl u_sram_strobe_ctrl (
      .clk(clk), .rst_n(rst_n),
      .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_done(host_done),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_drv(mem_drv),
      .mem_din(mem_din)
   );

   // Memory model: data valid only from the fourth cycle of a read.
   logic [7:0] model [32768];
   int         rd_age = 0;

   initial begin
      for (int i = 0; i < 32768; i++) model[i] = 8'(i) ^ 8'h5A;
   end

   always @(posedge clk) begin
      if (!mem_we_n && !mem_ce_n && mem_drv) model[mem_addr] <= mem_dout;
      if (!mem_ce_n && !mem_oe_n) rd_age <= rd_age + 1;
      else                        rd_age <= 0;
   end

   assign mem_din = (!mem_ce_n && !mem_oe_n && rd_age >= E_RD - 1) ? model[mem_addr] : 8'hEE;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Turnaround monitor (R6).
   int oe_hi_neg = 100;
   logic drv_prev = 1'b0;
   int contention = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_drv && !mem_oe_n) contention++;
         if (mem_drv && !drv_prev)
            check(oe_hi_neg - 1 >= E_TA, "R6 turnaround before drive", oe_hi_neg - 1, E_TA);
         oe_hi_neg = mem_oe_n ? oe_hi_neg + 1 : 0;
         drv_prev  = mem_drv;
      end
   end

   int lat, ce_lo, oe_lo, we_lo, drv_n, hold_n, addr_bad, dout_bad;
   logic [7:0] rdat;

   task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d,
                        input bit hold_req, input bit wr2, input logic [14:0] a2);
      lat = 0; ce_lo = 0; oe_lo = 0; we_lo = 0; drv_n = 0; hold_n = 0;
      addr_bad = 0; dout_bad = 0; rdat = '0;
      host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
      while (lat < 50) begin
         @(negedge clk);
         lat++;
         if (lat == 1) begin
            if (hold_req) begin host_wr = wr2; host_addr = a2; host_wdata = 8'h99; end
            else host_req = 1'b0;
         end
         if (!mem_ce_n) ce_lo++;
         if (!mem_oe_n) oe_lo++;
         if (!mem_we_n) we_lo++;
         if (mem_drv) drv_n++;
         if (mem_drv && mem_we_n) hold_n++;
         if ((!mem_ce_n || mem_drv) && mem_addr != a) addr_bad++;
         if (mem_drv && mem_dout != d) dout_bad++;
         if (host_done) begin
            rdat = host_rdata;
            host_req = 1'b0;
            break;
         end
      end
      @(negedge clk);
      check(!host_done, "R7 done single pulse", host_done, 0);
   endtask

   task automatic check_op(input bit wr, input logic [7:0] x);
      if (wr) begin
         check(lat == E_WLAT, "R7 write latency", lat, E_WLAT);
         check(we_lo == E_WP, "R4 write strobe width", we_lo, E_WP);
         check(oe_lo == 0, "R4 oe high in write", oe_lo, 0);
         check(hold_n == E_WH, "R5 hold after strobe", hold_n, E_WH);
         check(dout_bad == 0 && addr_bad == 0, "R5 addr/data stable", dout_bad + addr_bad, 0);
      end else begin
         check(lat == E_RLAT, "R7 read latency", lat, E_RLAT);
         check(oe_lo == E_RD && ce_lo == E_RD && we_lo == 0, "R2 read strobes", oe_lo, E_RD);
         check(addr_bad == 0, "R2 read address stable", addr_bad, 0);
         check(drv_n == 0, "R6 no drive in read", drv_n, 0);
         check(rdat == x, "R3 read data", rdat, x);
      end
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(mem_ce_n && mem_we_n && mem_oe_n && !mem_drv && !host_done,
            "R1 outputs in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_drv, host_done}, 5'b11100);
      rst_n = 1'b1;
      @(negedge clk);
      check(mem_ce_n && mem_we_n && mem_oe_n && !mem_drv && !host_done,
            "R1 outputs after reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_drv, host_done}, 5'b11100);

      foreach (VEC[i]) begin
         do_op(VEC[i].wr, VEC[i].a, VEC[i].d, 1'b0, 1'b0, '0);
         check_op(VEC[i].wr, VEC[i].x);
      end

      // R8: write request held through an active read is dropped.
      do_op(1'b0, 15'h0100, 8'h00, 1'b1, 1'b1, 15'h0200);
      check_op(1'b0, 8'h5A);
      check(we_lo == 0, "R8 held request ignored", we_lo, 0);
      repeat (3) begin
         @(negedge clk);
         check(mem_ce_n && !host_done, "R8 no extra access", {mem_ce_n, host_done}, 2'b10);
      end
      do_op(1'b0, 15'h0200, 8'h00, 1'b0, 1'b0, '0);
      check_op(1'b0, 8'h5A);

      // Read followed at once by a write (R6 turnaround watched by monitor).
      do_op(1'b0, 15'h0000, 8'h00, 1'b0, 1'b0, '0);
      check_op(1'b0, 8'hA5);
      do_op(1'b1, 15'h0001, 8'h77, 1'b0, 1'b0, '0);
      check_op(1'b1, 8'h00);
      do_op(1'b0, 15'h0001, 8'h00, 1'b0, 1'b0, '0);
      check_op(1'b0, 8'h77);
      check(contention == 0, "R6 drive with oe low", contention, 0);

      // R1: reset in the middle of a write.
      host_req = 1'b1; host_wr = 1'b1; host_addr = 15'h0055; host_wdata = 8'h11;
      @(negedge clk);
      host_req = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(mem_ce_n && mem_we_n && mem_oe_n && !mem_drv,
            "R1 reset aborts access", {mem_ce_n, mem_we_n, mem_oe_n, mem_drv}, 4'b1110);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule